// File: doc/BRIEF.md
# Packed Integer Saturating ALU

A 64-bit packed integer ALU that treats its two operands as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. It performs lane-wise add and subtract, with wraparound, unsigned saturation or signed saturation. It also performs lane-wise equality and signed greater-than compares and full-width bitwise logic. Each lane is computed on its own, and no carry or borrow passes between lanes. Compares return a mask: a lane is all ones when the condition holds and all zeros when it does not. The block produces no condition flags. Because of the mask format, a compare result can be fed straight into the logic operations to select lanes from two sources, for example `(mask AND a) OR (mask ANDNOT b)`.

Saturation is chosen on each request through the saturation input. Nothing is held between operations. The operands, opcode, lane size and saturation kind are sampled on a rising clock edge, and the result is available from the register that the same edge loads.

Top module: `pkalu_top`

## Requirements
- R1: While `rst_n` is low, `result_o` is zero. Reset is asynchronous and active low.
- R2: Each request is sampled on a rising edge, and its result appears on `result_o` after that edge. `size_i` encodes 0 = 8-bit lanes, 1 = 16-bit lanes, 2 or 3 = 32-bit lanes. Lane k occupies bits [k*W +: W]. Wraparound add and subtract (`sat_i` 0 or 3) keep the low W bits of each lane, with no carry or borrow crossing a lane boundary.
- R3: Add is `op_i` = 0. When `sat_i` = 1 (unsigned), a lane whose sum exceeds the unsigned maximum becomes all ones. When `sat_i` = 2 (signed), a lane that overflows becomes the signed maximum (0x7F for bytes), and a lane that underflows becomes the signed minimum (0x80 for bytes).
- R4: Subtract is `op_i` = 1 and computes a minus b. With unsigned saturation, a lane that would go below zero becomes 0. With signed saturation, a lane that overflows or underflows clamps to the signed maximum or minimum of the lane.
- R5: `op_i` = 2 sets each lane to all ones when the a lane equals the b lane, and to all zeros otherwise.
- R6: `op_i` = 3 sets each lane to all ones when the a lane is greater than the b lane as a signed two's-complement value, and to all zeros otherwise.
- R7: `op_i` 4, 5, 6 and 7 produce a AND b, (NOT a) AND b, a OR b and a XOR b over all 64 bits. `size_i` and `sat_i` have no effect on these operations.
- R8: For 32-bit lanes, an add or subtract that requests saturation (`sat_i` 1 or 2) gives the wraparound result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| op_i | input | 3 | Operation select |
| size_i | input | 2 | Lane size select |
| sat_i | input | 2 | Saturation kind for add and subtract |
| result_o | output | 64 | Registered result |

## Verification
The properties assume that every input is a known value at each rising edge after reset. They also assume that each request lasts exactly one cycle, so the result register always reflects the inputs sampled one edge earlier. The stimulus meets both conditions. It changes every input on the falling edge only, and it never leaves an input unknown. It mixes directed values at the lane limits, namely 0x7F, 0x80, 0xFF, 0x00 and their 16-bit and 32-bit counterparts, with random operands, opcodes, sizes and saturation codes. This includes the reserved saturation code 3 and the duplicate size code 3.

// File: rtl/pkalu_pkg.sv
package pkalu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CEQ  = 3'd2,
        OP_CGT  = 3'd3,
        OP_AND  = 3'd4,
        OP_ANDN = 3'd5,
        OP_OR   = 3'd6,
        OP_XOR  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SAT_WRAP = 2'd0,
        SAT_UNS  = 2'd1,
        SAT_SGN  = 2'd2,
        SAT_RSV  = 2'd3
    } sat_e;

endpackage

// File: rtl/pkalu_lane.sv
module pkalu_lane
    import pkalu_pkg::*;
#(
    parameter int W      = 8,
    parameter bit SAT_EN = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  sat_e         sat,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] UMAX = '1;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;
    logic [W:0] dif;
    logic       sovf_add;
    logic       sovf_sub;
    sat_e       mode;

    assign mode = SAT_EN ? sat : SAT_WRAP;

    always_comb begin
        sum      = {1'b0, a} + {1'b0, b};
        dif      = {1'b0, a} - {1'b0, b};
        sovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        sovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    end

    always_comb begin
        y = '0;
        unique case (op)
            OP_ADD: begin
                unique case (mode)
                    SAT_UNS: y = sum[W] ? UMAX : sum[W-1:0];
                    SAT_SGN: y = sovf_add ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
                    default: y = sum[W-1:0];
                endcase
            end
            OP_SUB: begin
                unique case (mode)
                    SAT_UNS: y = dif[W] ? '0 : dif[W-1:0];
                    SAT_SGN: y = sovf_sub ? (a[W-1] ? SMIN : SMAX) : dif[W-1:0];
                    default: y = dif[W-1:0];
                endcase
            end
            OP_CEQ:  y = (a == b) ? UMAX : '0;
            OP_CGT:  y = ($signed(a) > $signed(b)) ? UMAX : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pkalu_bitwise.sv
module pkalu_bitwise
    import pkalu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  op_e               op,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_ANDN: y = ~a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pkalu_top.sv
module pkalu_top
    import pkalu_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int MIN_LANE_W = 8,
    parameter int NUM_SIZES  = 3,
    parameter int SAT_MAX_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DATA_W-1:0]            a_i,
    input  logic [DATA_W-1:0]            b_i,
    input  logic [2:0]                   op_i,
    input  logic [$clog2(NUM_SIZES)-1:0] size_i,
    input  logic [1:0]                   sat_i,
    output logic [DATA_W-1:0]            result_o
);
    localparam int SZ_W = $clog2(NUM_SIZES);

    op_e               op;
    sat_e              sat;
    logic [SZ_W-1:0]   sz_idx;
    logic [DATA_W-1:0] arith_w [NUM_SIZES];
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] next_res;

    assign op     = op_e'(op_i);
    assign sat    = sat_e'(sat_i);
    assign sz_idx = (int'(size_i) >= NUM_SIZES) ? SZ_W'(NUM_SIZES - 1) : size_i;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = MIN_LANE_W << g;
        localparam int LN = DATA_W / LW;
        logic [DATA_W-1:0] packed_y;
        for (genvar l = 0; l < LN; l++) begin : g_lane
            pkalu_lane #(
                .W      (LW),
                .SAT_EN (LW <= SAT_MAX_W)
            ) u_lane (
                .a   (a_i[l*LW +: LW]),
                .b   (b_i[l*LW +: LW]),
                .op  (op),
                .sat (sat),
                .y   (packed_y[l*LW +: LW])
            );
        end
        assign arith_w[g] = packed_y;
    end

    pkalu_bitwise #(
        .DATA_W (DATA_W)
    ) u_bitwise (
        .a  (a_i),
        .b  (b_i),
        .op (op),
        .y  (bit_res)
    );

    assign next_res = op_i[2] ? bit_res : arith_w[sz_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
        end else begin
            result_o <= next_res;
        end
    end

endmodule

// File: rtl/pkalu_chk.sv
module pkalu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic [1:0]  sat_i,
    input logic [63:0] result_o
);
    function automatic logic bytes_ge(logic [63:0] x, logic [63:0] y);
        logic ok = 1'b1;
        for (int k = 0; k < 8; k++) if (x[k*8 +: 8] < y[k*8 +: 8]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic words_le(logic [63:0] x, logic [63:0] y);
        logic ok = 1'b1;
        for (int k = 0; k < 4; k++) if (x[k*16 +: 16] > y[k*16 +: 16]) ok = 1'b0;
        return ok;
    endfunction

    AST_USAT_ADD_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && sat_i == 2'd1 && size_i == 2'd0) |=> bytes_ge(result_o, $past(a_i))); // R3

    AST_USAT_SUB_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && sat_i == 2'd1 && size_i == 2'd1) |=> words_le(result_o, $past(a_i))); // R4

    AST_EQ_SAME_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && a_i == b_i) |=> (result_o == '1)); // R5

    AST_GT_SAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && a_i == b_i) |=> (result_o == '0)); // R6

    AST_ANDN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (result_o == (~$past(a_i) & $past(b_i)))); // R7

    AST_WIDE_ADD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && size_i >= 2'd2) |=>
        (result_o == {$past(a_i[63:32]) + $past(b_i[63:32]),
                      $past(a_i[31:0])  + $past(b_i[31:0])})); // R8

endmodule

bind pkalu_top pkalu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .sat_i    (sat_i),
    .result_o (result_o)
);

// File: tb/pkalu_top_tb.sv
module pkalu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [1:0]  sat_i = '0;
    logic [63:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pkalu_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (a_i),
        .b_i      (b_i),
        .op_i     (op_i),
        .size_i   (size_i),
        .sat_i    (sat_i),
        .result_o (result_o)
    );

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [2:0] op, logic [1:0] sz, logic [1:0] sat);
        int w;
        int s;
        logic [63:0] r = '0;
        longint m, ua, ub, sa, sb, v, smax, smin;
        case (op)
            3'd4: return a & b;
            3'd5: return ~a & b;
            3'd6: return a | b;
            3'd7: return a ^ b;
            default: ;
        endcase
        w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        s    = (w == 32) ? 0 : (sat == 2'd1) ? 1 : (sat == 2'd2) ? 2 : 0;
        m    = (longint'(1) << w) - 1;
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        for (int k = 0; k < 64 / w; k++) begin
            ua = longint'(a >> (k * w)) & m;
            ub = longint'(b >> (k * w)) & m;
            sa = (ua > smax) ? ua - (m + 1) : ua;
            sb = (ub > smax) ? ub - (m + 1) : ub;
            v  = 0;
            case (op)
                3'd0: begin
                    if (s == 2) begin
                        v = sa + sb;
                        if (v > smax) v = smax;
                        if (v < smin) v = smin;
                    end else begin
                        v = ua + ub;
                        if (s == 1 && v > m) v = m;
                    end
                end
                3'd1: begin
                    if (s == 2) begin
                        v = sa - sb;
                        if (v > smax) v = smax;
                        if (v < smin) v = smin;
                    end else begin
                        v = ua - ub;
                        if (s == 1 && v < 0) v = 0;
                    end
                end
                3'd2: v = (ua == ub) ? m : 0;
                default: v = (sa > sb) ? m : 0;
            endcase
            r = r | (64'(v & m) << (k * w));
        end
        return r;
    endfunction

    function automatic string tag(logic [2:0] op, logic [1:0] sz, logic [1:0] sat);
        if (op >= 3'd4) return "R7";
        if (op == 3'd2) return "R5";
        if (op == 3'd3) return "R6";
        if (sz >= 2'd2 && (sat == 2'd1 || sat == 2'd2)) return "R8";
        if (sat == 2'd0 || sat == 2'd3) return "R2";
        return (op == 3'd0) ? "R3" : "R4";
    endfunction

    task automatic check(string req, logic [63:0] exp);
        checks++;
        if (result_o !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, result_o, exp);
        end
    endtask

    task automatic step(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                        logic [1:0] sz, logic [1:0] sat);
        logic [63:0] exp;
        a_i = a; b_i = b; op_i = op; size_i = sz; sat_i = sat;
        exp = model(a, b, op, sz, sat);
        @(negedge clk);
        check(tag(op, sz, sat), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        a_i = 64'hFFFF_FFFF_FFFF_FFFF;
        b_i = 64'h1;
        repeat (2) @(negedge clk);
        check("R1", 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: lanes do not carry into neighbours
        step(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 3'd0, 2'd0, 2'd0);
        step(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd1, 2'd3);
        step(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 3'd1, 2'd0, 2'd0);
        // R3: add clamps
        step(64'hFF80_7F01_FEFF_0010, 64'h0101_0101_0301_00F0, 3'd0, 2'd0, 2'd1);
        step(64'h7F80_7F80_807F_0102, 64'h0180_7F80_01FF_7F7F, 3'd0, 2'd0, 2'd2);
        step(64'hFFFF_7FFF_8000_1234, 64'h0001_0001_8000_0001, 3'd0, 2'd1, 2'd1);
        step(64'hFFFF_7FFF_8000_1234, 64'h0001_0001_8000_0001, 3'd0, 2'd1, 2'd2);
        // R4: subtract clamps
        step(64'h0000_0510_8000_7FFF, 64'h0001_0610_0001_FFFF, 3'd1, 2'd1, 2'd1);
        step(64'h0000_0510_8000_7FFF, 64'h0001_0610_0001_FFFF, 3'd1, 2'd1, 2'd2);
        step(64'h8000_7F10_0080_7F00, 64'h0101_FF20_0100_8001, 3'd1, 2'd0, 2'd2);
        step(64'h0000_0510_8000_7FFF, 64'h0001_0610_0001_FFFF, 3'd1, 2'd0, 2'd1);
        // R8: 32-bit lanes ignore saturation
        step(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd2, 2'd1);
        step(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd3, 2'd2);
        step(64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, 3'd1, 2'd2, 2'd2);
        // R5 / R6: compares
        step(64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 3'd2, 2'd0, 2'd0);
        step(64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 3'd2, 2'd1, 2'd0);
        step(64'h807F_0001_FF00_7F80, 64'h7F80_0100_00FF_7F7F, 3'd3, 2'd0, 2'd0);
        step(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 3'd3, 2'd2, 2'd0);
        // R7: logic over all sizes
        for (int s = 0; s < 4; s++) begin
            step(64'hF0F0_CCCC_AAAA_0000, 64'hFF00_FF00_F0F0_FFFF, 3'd4, 2'(s), 2'(3 - s));
            step(64'hF0F0_CCCC_AAAA_0000, 64'hFF00_FF00_F0F0_FFFF, 3'd5, 2'(s), 2'(s));
            step(64'hF0F0_CCCC_AAAA_0000, 64'hFF00_FF00_F0F0_FFFF, 3'd6, 2'(s), 2'(s));
            step(64'hF0F0_CCCC_AAAA_0000, 64'hFF00_FF00_F0F0_FFFF, 3'd7, 2'(s), 2'(s));
        end
        // random mix, every op, size and saturation code
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
            step(ra, rb, 3'($urandom), 2'($urandom), 2'($urandom));
        end
        // R1: reset in mid-run clears result
        a_i = 64'h1234; b_i = 64'h1; op_i = 3'd6;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 64'h0);
        rst_n = 1'b1;
        step(64'h7F, 64'h01, 3'd0, 2'd0, 2'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule